// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one port of general-purpose pins with a parameterised width of up to 32 pins. A 32-bit register interface controls each pin. Each pin has a direction, an output value, a pull-up request and a two-bit function select. Every pin level passes through a synchroniser. Software reads the synchronised levels back at any time, whether the pin is an input or an output.

Each pin also has its own trigger unit. The unit can fire on a rising edge, a falling edge, either edge, a high level or a low level. A fired trigger lands in a per-pin status bit. A per-pin enable masks that status bit into the single interrupt request of the port. The enable mask has no direct write path. Software changes it only through a set address and a clear address, so separate agents can each change their own pins in one write without a read-modify-write race.

Top module: `gpio_trig_port`

## Requirements
- R1: Register word addresses on `bus_addr`:
  - 0 is direction, where a bit of 1 makes the pin an output. It drives `pin_oe`.
  - 1 is output data and drives `pin_out`.
  - 3 is pull-up enable and drives `pin_pullup`.
  - 4 and 5 are the low and high function-select bits and drive `pin_fsel0` and `pin_fsel1`.
  - Each of these addresses reads back the value last written to it.
- R2: Address 2 reads the level of each pin after a two-flop synchroniser. The level is visible two clock edges after `pin_in` changes and not after one. It is returned for output pins as well as input pins.
- R3: Trigger code bits are stored per pin at three addresses: address 6 holds code bit 0 (rising), address 7 holds code bit 1 (falling) and address 8 holds code bit 2 (level). In edge mode the status bit is set three clock edges after the pin change. Code 1 reacts to a rising edge, code 2 to a falling edge and code 3 to both edges.
- R4: Code 5 holds the status bit at 1 while the synchronised pin is high. Code 6 holds it at 1 while the pin is low. In both cases the status bit returns to 0 once the condition ends.
- R5: Codes 0, 4 and 7 never set the status bit, whatever the pin does.
- R6: Status (address 12) is sticky in edge mode and is cleared by writing 1 to the bit. Writing 0 leaves the bit unchanged. In level mode a clear has no effect while the condition still holds.
- R7: Writing 1s to address 10 sets enable bits, and writing 1s to address 11 clears them. Zero bits in these writes leave the other pins unchanged. Address 9 reads the enables, and writes to address 9 are ignored.
- R8: `irq` is high exactly when some pin has both its status bit and its enable bit at 1.
- R9: Write bits at or above PIN_COUNT are ignored, and those bit positions always read as 0.
- R10: After reset every register reads 0: all pins are inputs, and the function, pull-up, trigger, enable and status bits are clear. `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | PIN_COUNT | Pad input levels, asynchronous |
| pin_out | output | PIN_COUNT | Output data to pads |
| pin_oe | output | PIN_COUNT | Output enable per pin (1 = drive) |
| pin_pullup | output | PIN_COUNT | Pull-up request per pin |
| pin_fsel0 | output | PIN_COUNT | Function select, low bit |
| pin_fsel1 | output | PIN_COUNT | Function select, high bit |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the enable mask on every cycle:
- a set write turns its 1 bits on;
- a clear write turns its 1 bits off;
- the mask holds still unless one of those two addresses is written.

They also check that an edge-mode trigger fires only on a real change of the synchronised level, that codes with no single polarity never fire in level mode, and that `irq` never rises with an empty mask. The directed scenarios are what show:
- the exact latency of the synchroniser and the status bit;
- each trigger code against real pin waveforms;
- the difference between sticky edge status and level status;
- the masking of pin indices beyond the configured count.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR      = 4'd0,
        SEL_DOUT     = 4'd1,
        SEL_DIN      = 4'd2,
        SEL_PULL     = 4'd3,
        SEL_FN_LO    = 4'd4,
        SEL_FN_HI    = 4'd5,
        SEL_TRG_RISE = 4'd6,
        SEL_TRG_FALL = 4'd7,
        SEL_TRG_LVL  = 4'd8,
        SEL_IEN      = 4'd9,
        SEL_IEN_SET  = 4'd10,
        SEL_IEN_CLR  = 4'd11,
        SEL_STAT     = 4'd12
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl_now,
    output logic [W-1:0] lvl_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] hist;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_in;
        s_d.sync = s_q.meta;
        s_d.hist = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_now  = s_q.sync;
    assign lvl_prev = s_q.hist;

endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic rise_en,
    input  logic fall_en,
    input  logic lvl_sel,
    output logic hit
);

    logic went_up, went_down, one_pol;

    always_comb begin
        went_up   = lvl_now & ~lvl_prev;
        went_down = ~lvl_now & lvl_prev;
        one_pol   = rise_en ^ fall_en;
        if (lvl_sel)
            hit = one_pol & (rise_en ? lvl_now : ~lvl_now);
        else
            hit = (rise_en & went_up) | (fall_en & went_down);
    end

    // An edge-mode event needs an actual change of the synchronised level
    assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !lvl_sel) |-> (lvl_now != lvl_prev));

    // Level sense without exactly one polarity never fires
    assert_no_polarity_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel && (rise_en == fall_en)) |-> !hit);

endmodule

// File: rtl/gpio_trig_port.sv
module gpio_trig_port
    import gpio_trig_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [SEL_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_pullup,
    output logic [PIN_COUNT-1:0] pin_fsel0,
    output logic [PIN_COUNT-1:0] pin_fsel1,
    output logic                 irq
);

    localparam int unsigned P = PIN_COUNT;

    typedef struct packed {
        logic [P-1:0] dir;
        logic [P-1:0] dout;
        logic [P-1:0] pull;
        logic [P-1:0] fn_lo;
        logic [P-1:0] fn_hi;
        logic [P-1:0] trg_rise;
        logic [P-1:0] trg_fall;
        logic [P-1:0] trg_lvl;
        logic [P-1:0] ien;
        logic [P-1:0] stat;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic [P-1:0] wbits, w1c, lvl_now, lvl_prev, hit;
    logic         unused_wdata;

    assign sel          = reg_sel_e'(bus_addr);
    assign wbits        = bus_wdata[P-1:0];
    assign unused_wdata = ^bus_wdata;

    gpio_sync #(.W(P)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    for (genvar g = 0; g < P; g++) begin : g_pin
        gpio_pin_trig u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_now  (lvl_now[g]),
            .lvl_prev (lvl_prev[g]),
            .rise_en  (r_q.trg_rise[g]),
            .fall_en  (r_q.trg_fall[g]),
            .lvl_sel  (r_q.trg_lvl[g]),
            .hit      (hit[g])
        );
    end

    always_comb begin
        r_d = r_q;
        w1c = '0;
        if (bus_we) begin
            case (sel)
                SEL_DIR:      r_d.dir      = wbits;
                SEL_DOUT:     r_d.dout     = wbits;
                SEL_PULL:     r_d.pull     = wbits;
                SEL_FN_LO:    r_d.fn_lo    = wbits;
                SEL_FN_HI:    r_d.fn_hi    = wbits;
                SEL_TRG_RISE: r_d.trg_rise = wbits;
                SEL_TRG_FALL: r_d.trg_fall = wbits;
                SEL_TRG_LVL:  r_d.trg_lvl  = wbits;
                SEL_IEN_SET:  r_d.ien      = r_q.ien | wbits;
                SEL_IEN_CLR:  r_d.ien      = r_q.ien & ~wbits;
                SEL_STAT:     w1c          = wbits;
                default:      ;
            endcase
        end
        // level pins track their condition; edge pins latch until cleared
        r_d.stat = (r_q.trg_lvl & hit)
                 | (~r_q.trg_lvl & ((r_q.stat & ~w1c) | hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DIR:      bus_rdata[P-1:0] = r_q.dir;
            SEL_DOUT:     bus_rdata[P-1:0] = r_q.dout;
            SEL_DIN:      bus_rdata[P-1:0] = lvl_now;
            SEL_PULL:     bus_rdata[P-1:0] = r_q.pull;
            SEL_FN_LO:    bus_rdata[P-1:0] = r_q.fn_lo;
            SEL_FN_HI:    bus_rdata[P-1:0] = r_q.fn_hi;
            SEL_TRG_RISE: bus_rdata[P-1:0] = r_q.trg_rise;
            SEL_TRG_FALL: bus_rdata[P-1:0] = r_q.trg_fall;
            SEL_TRG_LVL:  bus_rdata[P-1:0] = r_q.trg_lvl;
            SEL_IEN:      bus_rdata[P-1:0] = r_q.ien;
            SEL_STAT:     bus_rdata[P-1:0] = r_q.stat;
            default:      ;
        endcase
    end

    assign pin_oe     = r_q.dir;
    assign pin_out    = r_q.dout;
    assign pin_pullup = r_q.pull;
    assign pin_fsel0  = r_q.fn_lo;
    assign pin_fsel1  = r_q.fn_hi;
    assign irq        = |(r_q.stat & r_q.ien);

    assert_ien_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'(SEL_IEN_SET))
        |=> ((r_q.ien & $past(bus_wdata[P-1:0])) == $past(bus_wdata[P-1:0])));

    assert_ien_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 4'(SEL_IEN_CLR))
        |=> ((r_q.ien & $past(bus_wdata[P-1:0])) == '0));

    assert_ien_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == 4'(SEL_IEN_SET) || bus_addr == 4'(SEL_IEN_CLR)))
        |=> $stable(r_q.ien));

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (r_q.ien != '0));

endmodule

// File: tb/test_gpio_trig_port.sv
module test_gpio_trig_port;

    localparam int unsigned NP = 20;
    localparam logic [31:0] ALLV = 32'h000F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_pullup, pin_fsel0, pin_fsel1;
    logic        irq;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    gpio_trig_port #(.PIN_COUNT(NP)) i_gpio_trig_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
        .pin_fsel0(pin_fsel0), .pin_fsel1(pin_fsel1), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(input int pin, input logic [2:0] code);
        wr(4'd6, 32'(code[0]) << pin);
        wr(4'd7, 32'(code[1]) << pin);
        wr(4'd8, 32'(code[2]) << pin);
    endtask

    task automatic fresh(input logic [NP-1:0] lv);
        set_code(0, 3'd0);
        pin_in = lv;
        idle(4);
        wr(4'd12, ALLV);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 13; a++) begin
            rd(4'(a), v);
            chk("R10 reg after reset", v, 32'h0);
        end
        chk("R10 irq after reset", 32'(irq), 32'h0);
        chk("R10 oe after reset", 32'(pin_oe), 32'h0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(4'd0, 32'h0000_0005);
        wr(4'd1, 32'h0000_0003);
        wr(4'd3, 32'h0000_0080);
        wr(4'd4, 32'h0000_0100);
        wr(4'd5, 32'h0008_0200);
        chk("R1 pin_oe", 32'(pin_oe), 32'h5);
        chk("R1 pin_out", 32'(pin_out), 32'h3);
        chk("R1 pin_pullup", 32'(pin_pullup), 32'h80);
        chk("R1 pin_fsel0", 32'(pin_fsel0), 32'h100);
        chk("R1 pin_fsel1", 32'(pin_fsel1), 32'h80200);
        rd(4'd5, v);
        chk("R1 fsel1 readback", v, 32'h80200);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 20'h000A5;
        idle(1);
        rd(4'd2, v);
        chk("R2 input not yet visible", v, 32'h0);
        idle(1);
        rd(4'd2, v);
        chk("R2 input after sync incl output pin", v, 32'hA5);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        fresh('0);
        set_code(4, 3'd1);
        pin_in[4] = 1'b1;
        idle(2);
        rd(4'd12, v);
        chk("R3 rise status not early", v, 32'h0);
        idle(1);
        rd(4'd12, v);
        chk("R3 rise status", v, 32'h10);
        pin_in[4] = 1'b0;
        idle(4);
        rd(4'd12, v);
        chk("R6 status sticky", v, 32'h10);
        wr(4'd12, 32'h0000_0008);
        rd(4'd12, v);
        chk("R6 zero bit leaves status", v, 32'h10);
        wr(4'd12, 32'h0000_0010);
        rd(4'd12, v);
        chk("R6 w1c clears", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        fresh(20'h00020);
        set_code(5, 3'd2);
        pin_in[5] = 1'b0;
        idle(3);
        rd(4'd12, v);
        chk("R3 fall status", v, 32'h20);
        wr(4'd12, 32'h20);
        pin_in[5] = 1'b1;
        idle(4);
        rd(4'd12, v);
        chk("R3 fall mode ignores rise", v, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        fresh('0);
        set_code(6, 3'd3);
        pin_in[6] = 1'b1;
        idle(3);
        rd(4'd12, v);
        chk("R3 both rise", v, 32'h40);
        wr(4'd12, 32'h40);
        pin_in[6] = 1'b0;
        idle(3);
        rd(4'd12, v);
        chk("R3 both fall", v, 32'h40);
    endtask

    task automatic t_level();
        logic [31:0] v;
        fresh('0);
        set_code(7, 3'd5);
        idle(2);
        rd(4'd12, v);
        chk("R4 high level idle", v, 32'h0);
        pin_in[7] = 1'b1;
        idle(3);
        rd(4'd12, v);
        chk("R4 high level fires", v, 32'h80);
        wr(4'd12, 32'h80);
        rd(4'd12, v);
        chk("R6 level clear ignored while held", v, 32'h80);
        pin_in[7] = 1'b0;
        idle(3);
        rd(4'd12, v);
        chk("R4 high level drops", v, 32'h0);
        fresh('0);
        set_code(8, 3'd6);
        idle(2);
        rd(4'd12, v);
        chk("R4 low level fires", v, 32'h100);
        pin_in[8] = 1'b1;
        idle(3);
        rd(4'd12, v);
        chk("R4 low level drops", v, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        logic [2:0] codes [3] = '{3'd0, 3'd4, 3'd7};
        for (int k = 0; k < 3; k++) begin
            fresh('0);
            set_code(9, codes[k]);
            pin_in[9] = 1'b1;
            idle(4);
            pin_in[9] = 1'b0;
            idle(4);
            rd(4'd12, v);
            chk($sformatf("R5 code %0d silent", codes[k]), v, 32'h0);
        end
    endtask

    task automatic t_enable();
        logic [31:0] v;
        fresh('0);
        set_code(4, 3'd1);
        pin_in[4] = 1'b1;
        idle(3);
        chk("R8 irq masked", 32'(irq), 32'h0);
        wr(4'd10, 32'h4);
        wr(4'd10, 32'h10);
        rd(4'd9, v);
        chk("R7 set accumulates", v, 32'h14);
        chk("R8 irq on", 32'(irq), 32'h1);
        wr(4'd11, 32'h4);
        rd(4'd9, v);
        chk("R7 clear one bit", v, 32'h10);
        wr(4'd9, 32'h0);
        rd(4'd9, v);
        chk("R7 direct write ignored", v, 32'h10);
        wr(4'd11, 32'h10);
        chk("R8 irq off with status held", 32'(irq), 32'h0);
        rd(4'd12, v);
        chk("R8 status still set", v, 32'h10);
        pin_in[4] = 1'b0;
    endtask

    task automatic t_range();
        logic [31:0] v;
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);
        chk("R9 dir upper bits zero", v, ALLV);
        chk("R9 pin_oe full", 32'(pin_oe), ALLV);
        wr(4'd10, 32'hFFF0_0000);
        rd(4'd9, v);
        chk("R9 enable upper ignored", v, 32'h0);
        rd(4'd13, v);
        chk("R9 unmapped reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_input();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_disabled();
        t_enable();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule